// File: doc/BRIEF.md
# Four-Channel Power-of-Two PWM Generator

This block produces four pulse-width modulated outputs from one shared free-running counter. A configuration register holds a run enable and a 4-bit shift amount. The counter is shifted right by that amount, and the low CMPW bits of the result form the scaled count. Each channel compares the scaled count with its own compare register. Because of this, the period is always a power of two clock cycles: 2^(CMPW + shift). The duty fraction of a channel is its compare value divided by 2^CMPW.

The outputs are active-low. A channel's pin is driven low while the scaled count is below its compare value, and it rests high otherwise. The largest compare value leaves exactly one scaled step high in every period, so the pin can never be low for a whole period. Software programs the block through a simple write port and reads it back through a combinational read port. Any write to the shift or to a compare value takes effect at the next clock edge, even in the middle of a period. One period can therefore combine a new length with an old duty value.

The counter is CMPW + 15 bits wide, so every shift setting has enough bits above it. When it reaches its top value it wraps to zero.

Top module: `pwm_scaled_bank`

## Requirements
- R1: Reset clears the counter, the configuration and all four compare registers, so every output pin reads 1 and every register reads 0.
- R2: The counter advances by one on each clock edge while the enable bit (configuration bit 12) is 1. It holds its value while that bit is 0.
- R3: The scaled count is counter bits [shift+CMPW-1 : shift], where shift is configuration bits [3:0] (0 to 15). The period is therefore 2^(CMPW+shift) clock cycles.
- R4: A channel is active while its scaled count is strictly less than its compare value. Its pin is the complement of that condition: 0 means active.
- R5: A compare value of 0 keeps the pin at 1 for the whole period.
- R6: The compare value 2^CMPW-1 leaves the pin at 1 for exactly 2^shift clock cycles per period, when the scaled count is at its maximum. A 100% duty cycle is never produced.
- R7: A write to the shift or to a compare value changes the outputs from the clock edge that accepts it, without waiting for a period boundary.
- R8: Register map, with byte offsets on an 8-bit address:
  - 0x00 is the configuration: shift in bits [3:0], enable in bit 12, all other bits read 0.
  - 0x08 is the counter, zero-extended to 32 bits.
  - 0x20, 0x24, 0x28 and 0x2C are the compare values of channels 0 to 3, held in the low CMPW bits.
  - Any other offset reads 0.
- R9: Writes to the counter offset and to unmapped offsets change no register.
- R10: The four channels share the counter and the shift but compare independently. A compare write affects only its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| pwm_n | output | 4 | Active-low channel outputs |

## Verification
The hardest situation to reach is a period that mixes settings: the shift or a compare value changes while the counter is partway through a period. Both the old and new alignments of the scaled count then matter. The stimulus runs partway into a period at one shift setting, then rewrites the shift and one compare value between edges. The bench's cycle-accurate model tracks the raw counter, so each pin is predicted through the transition. The largest shift setting is also exercised. Its long period cannot be completed, so the stimulus checks only that the scaled count holds still for many cycles and that the enable bit freezes and resumes the counter.

// File: rtl/pwm_scaled_pkg.sv
package pwm_scaled_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int SHIFT_W    = 4;
  localparam int EN_BIT     = 12;
  localparam int OFF_CFG    = 'h00;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_CMP0   = 'h20;
  localparam int NUM_CH     = 4;

  typedef struct packed {
    logic               run;
    logic [SHIFT_W-1:0] shift;
  } pwm_cfg_t;

  function automatic logic [ADDR_W-1:0] cmp_offset(input int ch);
    return ADDR_W'(OFF_CMP0 + 4 * ch);
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_scaled_pkg::*;
#(
  parameter int CMPW = 16,
  parameter int CNTW = CMPW + 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [CNTW-1:0]             count,
  output pwm_cfg_t                    cfg,
  output logic [NUM_CH-1:0][CMPW-1:0] cmp
);
  logic wr_data_unused;
  assign wr_data_unused = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(OFF_CFG)) begin
      cfg.run   <= wr_data[EN_BIT];
      cfg.shift <= wr_data[SHIFT_W-1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp[ch] <= '0;
      end else if (wr_en && wr_addr == cmp_offset(ch)) begin
        cmp[ch] <= wr_data[CMPW-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFF_CFG)) begin
      rd_data[EN_BIT]        = cfg.run;
      rd_data[SHIFT_W-1:0]   = cfg.shift;
    end else if (rd_addr == ADDR_W'(OFF_COUNT)) begin
      rd_data = DATA_W'(count);
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (rd_addr == cmp_offset(ch)) rd_data = DATA_W'(cmp[ch]);
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_scaled_pkg::*;
#(
  parameter int CMPW = 16,
  parameter int CNTW = CMPW + 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic [CNTW-1:0]    count,
  output logic [CMPW-1:0]    scaled
);
  function automatic logic [CMPW-1:0] slice_at(input logic [CNTW-1:0] value,
                                                input logic [SHIFT_W-1:0] amount);
    return CMPW'(value >> amount);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + CNTW'(1);
  end

  assign scaled = slice_at(count, shift);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CMPW = 16
) (
  input  logic [CMPW-1:0] scaled,
  input  logic [CMPW-1:0] cmp,
  output logic            pin_n
);
  logic active;
  assign active = scaled < cmp;
  assign pin_n  = ~active;
endmodule

// File: rtl/pwm_scaled_bank.sv
module pwm_scaled_bank
  import pwm_scaled_pkg::*;
#(
  parameter int CMPW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [3:0]        pwm_n
);
  localparam int CNTW = CMPW + 15;

  pwm_cfg_t                    cfg;
  logic [NUM_CH-1:0][CMPW-1:0] cmp;
  logic [CNTW-1:0]             count;
  logic [CMPW-1:0]             scaled;

  pwm_regs #(.CMPW(CMPW), .CNTW(CNTW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .count   (count),
    .cfg     (cfg),
    .cmp     (cmp)
  );

  pwm_counter #(.CMPW(CMPW), .CNTW(CNTW)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cfg.run),
    .shift  (cfg.shift),
    .count  (count),
    .scaled (scaled)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_channel #(.CMPW(CMPW)) u_ch (
      .scaled (scaled),
      .cmp    (cmp[ch]),
      .pin_n  (pwm_n[ch])
    );
  end
endmodule

// File: rtl/pwm_scaled_bank_chk.sv
module pwm_scaled_bank_chk #(
  parameter int CMPW = 16,
  parameter int CNTW = CMPW + 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic [CNTW-1:0]       count,
  input logic [CMPW-1:0]       scaled,
  input logic [3:0][CMPW-1:0]  cmp,
  input logic [3:0]            pwm_n
);
  // R1: while reset is held, the counter is zero and every pin is inactive
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (count == '0 && pwm_n == 4'hF));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> count == $past(count) + CNTW'(1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  for (genvar ch = 0; ch < 4; ch++) begin : g_pin
    assert_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp[ch] == '0 |-> pwm_n[ch]);

    assert_never_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      scaled == '1 |-> pwm_n[ch]);
  end
endmodule

bind pwm_scaled_bank pwm_scaled_bank_chk #(.CMPW(CMPW), .CNTW(CNTW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (cfg.run),
  .count  (count),
  .scaled (scaled),
  .cmp    (cmp),
  .pwm_n  (pwm_n)
);

// File: tb/test_pwm_scaled_bank.sv
module test_pwm_scaled_bank;
  localparam int  CLK_PERIOD = 10;
  localparam int  CMPW       = 8;
  localparam int  CNTW       = CMPW + 15;
  localparam longint CMASK   = (64'd1 << CNTW) - 1;
  localparam int  SMASK      = (1 << CMPW) - 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_n;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  bit done   = 0;
  string req = "R1";

  // behavioural reference state
  longint m_count;
  int     m_shift;
  bit     m_run;
  int     m_cmp[4];

  pwm_scaled_bank #(.CMPW(CMPW)) i_pwm_scaled_bank (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .pwm_n
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_count = 0; m_shift = 0; m_run = 0;
      foreach (m_cmp[i]) m_cmp[i] = 0;
    end else begin
      if (m_run) m_count = (m_count + 1) & CMASK;
      if (wr_en) begin
        if (wr_addr == 8'h00) begin
          m_run   = wr_data[12];
          m_shift = int'(wr_data[3:0]);
        end
        for (int i = 0; i < 4; i++)
          if (wr_addr == 8'(32 + 4*i)) m_cmp[i] = int'(wr_data) & SMASK;
      end
    end
  end

  function automatic logic [3:0] exp_pins();
    int sc = int'((m_count >> m_shift) & SMASK);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = !(sc < m_cmp[i]);
    return p;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return 32'(m_shift) | (32'(m_run) << 12);
    if (a == 8'h08) return 32'(m_count);
    for (int i = 0; i < 4; i++) if (a == 8'(32 + 4*i)) return 32'(m_cmp[i]);
    return 32'h0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      check(req, "pins", 32'(pwm_n), 32'(exp_pins()));
      check(req, "read", rd_data, exp_read(rd_addr));
    end
  end

  task automatic write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run(input int n);
    logic [7:0] addrs[7] = '{8'h00, 8'h08, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h10};
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      rd_addr = addrs[k % 7];
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 3);
    rd_addr = 8'h00; #1;
    check("R1", "cfg at reset", rd_data, 32'h0);
    check("R1", "pins at reset", 32'(pwm_n), 32'hF);
    rst_n = 1;
    live = 1;
    run(8);

    // R2 / R10: program compares while stopped, counter must hold
    req = "R2";
    write(8'h20, 32'h0);
    write(8'h24, 32'h1);
    write(8'h28, 32'h80);
    write(8'h2C, 32'hFFFF_FFFF);
    run(20);

    // R4 / R10: run at shift 0
    req = "R4";
    write(8'h00, 32'h0000_1000);
    run(600);

    // R9: writes to the counter and unmapped offsets are ignored
    req = "R9";
    write(8'h08, 32'h0000_1234);
    write(8'h10, 32'hFFFF_FFFF);
    write(8'h40, 32'hFFFF_FFFF);
    run(14);

    // R3: shift 2 over more than one period
    req = "R3";
    write(8'h00, 32'h0000_1002);
    run(1200);

    // R7: change shift and one compare mid-period
    req = "R7";
    run(300);
    write(8'h00, 32'h0000_1001);
    write(8'h28, 32'h40);
    run(600);

    // R5 / R6: zero and full-scale compares over whole periods at shift 0
    req = "R6";
    write(8'h00, 32'h0000_1000);
    run(700);

    // R8: stray config bits read back as zero
    req = "R8";
    write(8'h00, 32'hFFFF_FFF5);
    rd_addr = 8'h00; #1;
    check("R8", "cfg readback", rd_data, 32'h0000_1005);
    run(300);

    // R2: stop and resume
    req = "R2";
    write(8'h00, 32'h0000_0005);
    run(60);
    write(8'h00, 32'h0000_1005);
    run(60);

    // R3: largest shift
    req = "R3";
    write(8'h00, 32'h0000_100F);
    run(200);

    // R10: one channel's write leaves others alone
    req = "R10";
    write(8'h24, 32'h33);
    run(40);

    // R1: reset mid-run
    req = "R1";
    @(posedge clk); #1;
    rst_n = 0;
    #1;
    check("R1", "pins during reset", 32'(pwm_n), 32'hF);
    rd_addr = 8'h08; #1;
    check("R1", "count during reset", rd_data, 32'h0);
    run(3);
    rst_n = 1;
    run(20);

    finish_run();
  end
endmodule